// File: doc/BRIEF.md
# Multi-Lane SPI Programmed-I/O Transfer Engine

This block is a half-duplex serial flash master driven directly by a processor, with no descriptor engine behind it. Software first writes a transfer setup word. The setup word gives the direction, the lane width (one, two or four data lines) and whether chip select should stay asserted after the transfer. Software then supplies the payload, or drains it, through two byte-oriented FIFOs. Writing a non-zero byte count starts the transfer. The engine generates SPI mode 0 timing at single data rate, with each serial clock phase lasting two core cycles.

Outgoing bytes enter the write FIFO one byte per access on a byte port or four bytes per access on a word port. Incoming bytes collect in the read FIFO, and software pops up to four of them at a time. Two status words report the write FIFO space and the read FIFO occupancy in bytes. Level outputs signal that the write FIFO has drained and that read data is waiting. Sticky flags record a push into a full write FIFO and a pop from an empty read FIFO.

When lanes 2 and 3 are not carrying quad data, they act as the write-protect and hold lines.

Top module: `spi_pio_engine`

## Requirements
- R1: A pulse on `startWe` with a non-zero `startCount` while idle starts a transfer of that many bytes, and `xferStatus[0]` (busy) reads 1 until the last byte has moved. A count of zero starts nothing.
- R2: The setup word uses bit 0 for direction (1 = write, 0 = read), bits 3:1 for lane mode (1 = single, 2 = dual, 3 = quad; any other value means single) and bit 8 for the hold-select flag. A setup write with any of bits 7:4 set is dropped. The setup is captured at start, so a later setup write does not alter a running transfer.
- R3: `csSel` captured at start chooses which line is driven low: 0 selects `csN[0]` and 1 selects `csN[1]`. At most one line is ever low.
- R4: When the hold-select flag is clear, chip select returns high after the last byte. When it is set, chip select stays low after the transfer ends.
- R5: `sclk` idles low. Each high phase and each low phase lasts two core cycles, and one byte at single lane takes eight rising edges.
- R6: Data moves most significant bit first. Single mode drives `ioOut[0]` and samples `ioIn[1]`. Dual mode moves two bits per clock on lanes 1:0, with lane 1 as the higher bit. Quad mode moves a nibble per clock on lanes 3:0, high nibble first, with lane 3 as the highest bit. In a write, `ioOe` enables exactly the lanes in use.
- R7: A byte-port write queues one byte. A word-port write queues four bytes, and bits 7:0 go on the wire first.
- R8: `xferStatus[31:16]` is the number of bytes the write FIFO can still take. `wrEmpty` is high when the write FIFO holds no bytes.
- R9: `rdStatus[0]` is high when read data is present, `rdStatus[10:4]` is the stored byte count, and `rdStatus[11]` is high when the FIFO is empty. `rdReady` mirrors `rdStatus[0]`.
- R10: A `rdPop` removes up to four bytes. `rdData` shows the earliest byte in bits 7:0 and later bytes in higher lanes, and lanes beyond the stored count read zero.
- R11: A push that does not fit in the write FIFO is dropped and sets `errFlags[0]`. A pop from an empty read FIFO sets `errFlags[1]`. Each flag stays set until software writes a 1 to the matching `errClr` bit.
- R12: Outside a quad transfer, lane 2 is driven high when `wpEn` is set and lane 3 is driven high when `holdEn` is set. A lane whose enable is clear is released.
- R13: During a read transfer, the engine drives none of lanes 1:0.
- R14: When a write needs a byte and the write FIFO is empty, the engine waits with `sclk` low and chip select held, then resumes when data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four times the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Setup word write strobe |
| cfgData | input | 9 | Setup word: direction, lane mode, hold-select flag |
| startWe | input | 1 | Byte-count write strobe, starts a transfer |
| startCount | input | 16 | Number of bytes to transfer |
| csSel | input | 1 | Chip-select choice |
| holdEn | input | 1 | Drive the hold line (lane 3) high |
| wpEn | input | 1 | Drive the write-protect line (lane 2) high |
| wrByteWe | input | 1 | Push one byte into the write FIFO |
| wrByteData | input | 8 | Byte to push |
| wrWordWe | input | 1 | Push four bytes into the write FIFO |
| wrWordData | input | 32 | Word to push, bits 7:0 first |
| rdPop | input | 1 | Pop up to four bytes from the read FIFO |
| rdData | output | 32 | Head of the read FIFO, earliest byte in bits 7:0 |
| errClr | input | 2 | Write-one-to-clear for the error flags |
| xferStatus | output | 32 | Write FIFO space in 31:16, busy in bit 0 |
| rdStatus | output | 12 | Read FIFO empty, count and ready fields |
| errFlags | output | 2 | Bit 0 overrun, bit 1 underrun |
| wrEmpty | output | 1 | Write FIFO holds no data |
| rdReady | output | 1 | Read FIFO holds data |
| sclk | output | 1 | Serial clock |
| csN | output | 2 | Active-low chip selects |
| ioOut | output | 4 | Lane output values |
| ioOe | output | 4 | Lane output enables |
| ioIn | input | 4 | Lane input values |

## Verification
The assertions assume that software never raises `wrByteWe` and `wrWordWe` in the same cycle. They also assume that the attached device changes `ioIn` only after a falling `sclk` edge, so every value is stable at the rising edge that samples it. The bench drives the two push ports strictly one at a time. Its device model moves to the next symbol only on falling `sclk` edges and presents the first symbol before the transfer begins, so every sample falls inside a stable window.

// File: rtl/spi_pio_pkg.sv
package spi_pio_pkg;

  typedef enum logic [1:0] {
    LANE_1 = 2'd0,
    LANE_2 = 2'd1,
    LANE_4 = 2'd2
  } lane_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadSr;
    logic shiftOut;
    logic sampleIn;
    logic pushRd;
    logic popWr;
  } strobe_t;

  typedef struct packed {
    logic  holdCs;
    lane_e lanes;
    logic  isWrite;
  } xcfg_t;

  function automatic lane_e decodeMode(input logic [2:0] m);
    case (m)
      3'd2:    return LANE_2;
      3'd3:    return LANE_4;
      default: return LANE_1;
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
// Byte-granular FIFO that accepts and releases up to four bytes per cycle.
// DEPTH must be a power of two.
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int PEEK  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [2:0]                 pushN,
  input  logic [31:0]                pushData,
  input  logic [2:0]                 popN,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [8*PEEK-1:0]          peek
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushN);
      rdPtr <= rdPtr + AW'(popN);
      count <= count + CW'(pushN) - CW'(popN);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (3'(i) < pushN) mem[wrPtr + AW'(i)] <= pushData[8*i +: 8];
  end

  always_comb begin
    for (int i = 0; i < PEEK; i++) peek[8*i +: 8] = mem[rdPtr + AW'(i)];
  end

  // R11: callers never overfill or over-drain the store
  a_r11_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    (32'(count) + 32'(pushN)) <= (32'(DEPTH) + 32'(popN)));
  a_r11_drain_bound: assert property (@(posedge clk) disable iff (!rstN)
    32'(popN) <= 32'(count));

endmodule

// File: rtl/spi_pio_datapath.sv
module spi_pio_datapath
  import spi_pio_pkg::*;
#(
  parameter int WR_DEPTH = 64,
  parameter int RD_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  lane_e       lanes,
  input  logic        busy,
  input  logic        isWrite,
  input  logic        holdEn,
  input  logic        wpEn,
  input  logic        wrByteWe,
  input  logic [7:0]  wrByteData,
  input  logic        wrWordWe,
  input  logic [31:0] wrWordData,
  input  logic        rdPop,
  input  logic [1:0]  errClr,
  input  logic [3:0]  ioIn,
  output logic        wrHasData,
  output logic        rdHasSpace,
  output logic [15:0] wrFree,
  output logic [6:0]  rdCount7,
  output logic [31:0] rdData,
  output logic [1:0]  errFlags,
  output logic [3:0]  ioOut,
  output logic [3:0]  ioOe
);
  localparam int WCW = $clog2(WR_DEPTH + 1);
  localparam int RCW = $clog2(RD_DEPTH + 1);

  logic [WCW-1:0] wrCount, wrFreeN;
  logic [RCW-1:0] rdCount;
  logic [7:0]     wrPeek;
  logic [31:0]    rdPeek, wrPushData;
  logic [2:0]     wrPushN, rdPopN;
  logic           ovrSet, udrSet, ovrFlag, udrFlag;
  logic [7:0]     sr;

  assign wrFreeN = WCW'(WR_DEPTH) - wrCount;

  always_comb begin
    wrPushN = 3'd0;
    ovrSet  = 1'b0;
    if (wrWordWe) begin
      if (wrFreeN >= WCW'(4)) wrPushN = 3'd4;
      else ovrSet = 1'b1;
    end else if (wrByteWe) begin
      if (wrFreeN != '0) wrPushN = 3'd1;
      else ovrSet = 1'b1;
    end
    wrPushData = wrWordWe ? wrWordData : {24'b0, wrByteData};
  end

  assign rdPopN = !rdPop ? 3'd0 : (rdCount >= RCW'(4)) ? 3'd4 : 3'(rdCount);
  assign udrSet = rdPop && (rdCount == '0);

  spi_byte_fifo #(.DEPTH(WR_DEPTH), .PEEK(1)) i_wrFifo (
    .clk(clk), .rstN(rstN), .pushN(wrPushN), .pushData(wrPushData),
    .popN({2'b00, stb.popWr}), .count(wrCount), .peek(wrPeek));

  spi_byte_fifo #(.DEPTH(RD_DEPTH), .PEEK(4)) i_rdFifo (
    .clk(clk), .rstN(rstN), .pushN({2'b00, stb.pushRd}), .pushData({24'b0, sr}),
    .popN(rdPopN), .count(rdCount), .peek(rdPeek));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrFlag <= 1'b0;
      udrFlag <= 1'b0;
    end else begin
      ovrFlag <= ovrSet | (ovrFlag & ~errClr[0]);
      udrFlag <= udrSet | (udrFlag & ~errClr[1]);
    end
  end

  // lane shift register: MSB leaves first, new bits enter at the bottom
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sr <= '0;
    else if (stb.loadSr) sr <= wrPeek;
    else if (stb.shiftOut)
      case (lanes)
        LANE_2:  sr <= {sr[5:0], 2'b00};
        LANE_4:  sr <= {sr[3:0], 4'b0000};
        default: sr <= {sr[6:0], 1'b0};
      endcase
    else if (stb.sampleIn)
      case (lanes)
        LANE_2:  sr <= {sr[5:0], ioIn[1:0]};
        LANE_4:  sr <= {sr[3:0], ioIn};
        default: sr <= {sr[6:0], ioIn[1]};
      endcase
  end

  always_comb begin
    for (int i = 0; i < 4; i++)
      rdData[8*i +: 8] = (RCW'(i) < rdCount) ? rdPeek[8*i +: 8] : 8'h00;
  end

  // pins: lanes 2/3 are wp/hold unless a quad transfer owns them
  always_comb begin
    ioOut = 4'b1100;
    ioOe  = {holdEn, wpEn, 2'b00};
    if (busy && lanes == LANE_4) ioOe[3:2] = 2'b00;
    if (busy && isWrite)
      case (lanes)
        LANE_2:  begin ioOut[1:0] = sr[7:6]; ioOe[1:0] = 2'b11; end
        LANE_4:  begin ioOut = sr[7:4]; ioOe = 4'b1111; end
        default: begin ioOut[0] = sr[7]; ioOe[0] = 1'b1; end
      endcase
  end

  assign wrHasData  = wrCount != '0;
  assign rdHasSpace = rdCount < RCW'(RD_DEPTH);
  assign wrFree     = 16'(wrFreeN);
  assign rdCount7   = 7'(rdCount);
  assign errFlags   = {udrFlag, ovrFlag};

  // R11: error flags persist until written with one
  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag && !errClr[0] |=> ovrFlag);
  a_r11_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    udrFlag && !errClr[1] |=> udrFlag);

endmodule

// File: rtl/spi_pio_control.sv
module spi_pio_control
  import spi_pio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [8:0]  cfgData,
  input  logic        startWe,
  input  logic [15:0] startCount,
  input  logic        csSel,
  input  logic        wrHasData,
  input  logic        rdHasSpace,
  output strobe_t     stb,
  output logic        busy,
  output logic        isWrite,
  output lane_e       lanes,
  output logic        sclk,
  output logic [1:0]  csN
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_END} state_e;

  state_e      state;
  xcfg_t       cfgReg, act;
  logic [1:0]  ph;
  logic [2:0]  clkCnt, lastCnt;
  logic [15:0] remain;
  logic        csActive, csLat, lastClk;

  assign lastCnt = (act.lanes == LANE_4) ? 3'd1 : (act.lanes == LANE_2) ? 3'd3 : 3'd7;
  assign lastClk = clkCnt == lastCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '{holdCs: 1'b0, lanes: LANE_1, isWrite: 1'b0};
    else if (cfgWe && cfgData[7:4] == 4'b0000)
      cfgReg <= '{holdCs: cfgData[8], lanes: decodeMode(cfgData[3:1]), isWrite: cfgData[0]};
  end

  always_comb begin
    stb = '0;
    case (state)
      S_LOAD: if (act.isWrite && wrHasData) begin
        stb.loadSr = 1'b1;
        stb.popWr  = 1'b1;
      end
      S_SHIFT: begin
        stb.sampleIn = !act.isWrite && ph == 2'd1;
        stb.shiftOut = act.isWrite && ph == 2'd3 && !lastClk;
        stb.pushRd   = !act.isWrite && ph == 2'd3 && lastClk;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      act      <= '{holdCs: 1'b0, lanes: LANE_1, isWrite: 1'b0};
      ph       <= '0;
      clkCnt   <= '0;
      remain   <= '0;
      csActive <= 1'b0;
      csLat    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startWe && startCount != 16'd0) begin
          act      <= cfgReg;
          remain   <= startCount;
          csActive <= 1'b1;
          csLat    <= csSel;
          state    <= S_LOAD;
        end
        S_LOAD: if (act.isWrite ? wrHasData : rdHasSpace) begin
          ph     <= '0;
          clkCnt <= '0;
          state  <= S_SHIFT;
        end
        S_SHIFT: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            if (lastClk) begin
              clkCnt <= '0;
              remain <= remain - 16'd1;
              state  <= (remain == 16'd1) ? S_END : S_LOAD;
            end else begin
              clkCnt <= clkCnt + 3'd1;
            end
          end
        end
        default: begin
          csActive <= act.holdCs;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  assign busy    = state != S_IDLE;
  assign isWrite = act.isWrite;
  assign lanes   = act.lanes;
  assign sclk    = state == S_SHIFT && ph[1];
  assign csN     = ~({csLat, ~csLat} & {2{csActive}});

  // R5: each serial clock phase spans at least two core cycles
  a_r5_high_two: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |=> sclk);
  a_r5_low_two: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |=> !sclk);
  // R1: a running transfer always has a chip select asserted
  a_r1_busy_selects: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> csN != 2'b11);

endmodule

// File: rtl/spi_pio_engine.sv
module spi_pio_engine
  import spi_pio_pkg::*;
#(
  parameter int WR_DEPTH = 64,
  parameter int RD_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [8:0]  cfgData,
  input  logic        startWe,
  input  logic [15:0] startCount,
  input  logic        csSel,
  input  logic        holdEn,
  input  logic        wpEn,
  input  logic        wrByteWe,
  input  logic [7:0]  wrByteData,
  input  logic        wrWordWe,
  input  logic [31:0] wrWordData,
  input  logic        rdPop,
  output logic [31:0] rdData,
  input  logic [1:0]  errClr,
  output logic [31:0] xferStatus,
  output logic [11:0] rdStatus,
  output logic [1:0]  errFlags,
  output logic        wrEmpty,
  output logic        rdReady,
  output logic        sclk,
  output logic [1:0]  csN,
  output logic [3:0]  ioOut,
  output logic [3:0]  ioOe,
  input  logic [3:0]  ioIn
);
  strobe_t     stb;
  lane_e       lanes;
  logic        busy, isWrite, wrHasData, rdHasSpace;
  logic [15:0] wrFree;
  logic [6:0]  rdCount7;

  spi_pio_control i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .startWe(startWe), .startCount(startCount), .csSel(csSel),
    .wrHasData(wrHasData), .rdHasSpace(rdHasSpace), .stb(stb),
    .busy(busy), .isWrite(isWrite), .lanes(lanes), .sclk(sclk), .csN(csN));

  spi_pio_datapath #(.WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lanes(lanes), .busy(busy),
    .isWrite(isWrite), .holdEn(holdEn), .wpEn(wpEn), .wrByteWe(wrByteWe),
    .wrByteData(wrByteData), .wrWordWe(wrWordWe), .wrWordData(wrWordData),
    .rdPop(rdPop), .errClr(errClr), .ioIn(ioIn), .wrHasData(wrHasData),
    .rdHasSpace(rdHasSpace), .wrFree(wrFree), .rdCount7(rdCount7),
    .rdData(rdData), .errFlags(errFlags), .ioOut(ioOut), .ioOe(ioOe));

  assign xferStatus = {wrFree, 15'b0, busy};
  assign rdReady    = rdCount7 != 7'd0;
  assign wrEmpty    = !wrHasData;
  assign rdStatus   = {!rdReady, rdCount7, 3'b000, rdReady};

  // R3: never more than one chip select low
  a_r3_one_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  // R13: a read transfer leaves the data lanes undriven
  a_r13_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busy && !isWrite |-> ioOe[1:0] == 2'b00);

endmodule

// File: tb/test_spi_pio_engine.sv
module test_spi_pio_engine;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        cfgWe = 0, startWe = 0, csSel = 0, holdEn = 1, wpEn = 1;
  logic        wrByteWe = 0, wrWordWe = 0, rdPop = 0;
  logic [8:0]  cfgData = '0;
  logic [15:0] startCount = '0;
  logic [7:0]  wrByteData = '0;
  logic [31:0] wrWordData = '0, rdData, xferStatus;
  logic [1:0]  errClr = '0, errFlags, csN;
  logic [11:0] rdStatus;
  logic        wrEmpty, rdReady, sclk;
  logic [3:0]  ioOut, ioOe, ioIn;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_pio_engine i_spi_pio_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .startWe(startWe),
    .startCount(startCount), .csSel(csSel), .holdEn(holdEn), .wpEn(wpEn),
    .wrByteWe(wrByteWe), .wrByteData(wrByteData), .wrWordWe(wrWordWe),
    .wrWordData(wrWordData), .rdPop(rdPop), .rdData(rdData), .errClr(errClr),
    .xferStatus(xferStatus), .rdStatus(rdStatus), .errFlags(errFlags),
    .wrEmpty(wrEmpty), .rdReady(rdReady), .sclk(sclk), .csN(csN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn));

  // ---- device model ----
  int          benchW = 1;
  int          capIdx = 0, capBits = 0, capAcc = 0;
  logic [7:0]  capBytes [512];
  int          symIdx = 0, symBase = 0;
  logic [31:0] srcWord = '0;
  int          rel, spb, bi, pos;
  logic [7:0]  srcByte, sym;
  int          rises = 0, hiCycles = 0;

  always @(posedge sclk) begin
    rises++;
    capAcc = (capAcc << benchW) |
             ((benchW == 1) ? int'(ioOut[0]) : (benchW == 2) ? int'(ioOut[1:0]) : int'(ioOut));
    capBits += benchW;
    if (capBits >= 8) begin
      capBytes[capIdx % 512] = capAcc[7:0];
      capIdx++;
      capBits = 0;
      capAcc = 0;
    end
  end

  always @(negedge sclk) symIdx++;
  always @(negedge clk) if (sclk) hiCycles++;

  always_comb begin
    rel = symIdx - symBase;
    spb = 8 / benchW;
    bi  = rel / spb;
    pos = rel % spb;
    srcByte = 8'(srcWord >> (8 * (bi % 4)));
    sym = 8'((srcByte >> (8 - benchW * (pos + 1))) & ((1 << benchW) - 1));
    ioIn = (benchW == 1) ? {2'b00, sym[0], 1'b0} : sym[3:0];
  end

  // ---- helpers ----
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input bit wr, input int mode, input bit hold);
    @(negedge clk);
    cfgData = {hold, 4'b0000, 3'(mode), wr};
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    benchW = (mode == 2) ? 2 : (mode == 3) ? 4 : 1;
  endtask

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk); wrWordData = w; wrWordWe = 1'b1;
    @(negedge clk); wrWordWe = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); wrByteData = b; wrByteWe = 1'b1;
    @(negedge clk); wrByteWe = 1'b0;
  endtask

  task automatic start(input int n);
    @(negedge clk); startCount = 16'(n); startWe = 1'b1;
    @(negedge clk); startWe = 1'b0;
  endtask

  task automatic waitIdle();
    while (xferStatus[0]) @(negedge clk);
  endtask

  task automatic popRead(output logic [31:0] d);
    @(negedge clk); rdPop = 1'b1;
    #5 d = rdData;
    @(negedge clk); rdPop = 1'b0;
  endtask

  // {dir, mode, nbytes, data}
  localparam logic [39:0] VEC [6] = '{
    {1'b1, 3'd1, 4'd4, 32'hC35A810F},
    {1'b1, 3'd2, 4'd4, 32'h12345678},
    {1'b1, 3'd3, 4'd4, 32'hF0E1D2C3},
    {1'b0, 3'd1, 4'd4, 32'hA5968778},
    {1'b0, 3'd2, 4'd3, 32'h003CE719},
    {1'b0, 3'd3, 4'd4, 32'h5E6F7A8B}
  };

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, exp;
    int base, r0, h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk(csN == 2'b11 && !sclk, "R1 reset cs/sclk", {30'b0, csN}, 32'h3);
    chk(xferStatus == {16'd64, 16'd0}, "R8 reset status", xferStatus, {16'd64, 16'd0});
    chk(rdStatus == 12'h800 && !rdReady && wrEmpty, "R9 reset read status", 32'(rdStatus), 32'h800);
    chk(errFlags == 2'b00, "R11 reset flags", 32'(errFlags), 0);
    chk(ioOe == 4'b1100 && ioOut[3:2] == 2'b11, "R12 idle hold/wp", {ioOut, ioOe}, 32'hC);

    // table walk
    foreach (VEC[v]) begin
      logic isWr; int mode, n; logic [31:0] data; logic [3:0] oeExp;
      isWr = VEC[v][39]; mode = int'(VEC[v][38:36]); n = int'(VEC[v][35:32]); data = VEC[v][31:0];
      setCfg(isWr, mode, 1'b0);
      if (isWr) begin
        oeExp = (mode == 3) ? 4'hF : (mode == 2) ? 4'hF & 4'b1111 : 4'hD;
        if (mode == 2) oeExp = 4'b1111;
        base = capIdx;
        pushWord(data);
        start(4);
        repeat (3) @(negedge clk);
        chk(ioOe == oeExp, "R6 write lane enables", 32'(ioOe), 32'(oeExp));
        waitIdle();
        for (int k = 0; k < 4; k++)
          chk(capBytes[(base + k) % 512] == data[8*k +: 8], "R6 R7 R2 wire byte",
              32'(capBytes[(base + k) % 512]), 32'(data[8*k +: 8]));
        chk(csN == 2'b11, "R4 cs released", 32'(csN), 3);
      end else begin
        srcWord = data;
        symBase = symIdx;
        start(n);
        repeat (3) @(negedge clk);
        chk(ioOe[1:0] == 2'b00 && xferStatus[0], "R13 read lanes quiet", 32'(ioOe), 32'(ioOe & 4'hC));
        waitIdle();
        chk(rdStatus == {1'b0, 7'(n), 3'b000, 1'b1} && rdReady, "R9 read count",
            32'(rdStatus), 32'({1'b0, 7'(n), 3'b000, 1'b1}));
        popRead(d);
        exp = (n == 4) ? data : (data & 32'h00FFFFFF);
        chk(d == exp, "R10 R6 R2 read data", d, exp);
        chk(rdStatus == 12'h800, "R9 empty after pop", 32'(rdStatus), 32'h800);
      end
    end

    // R1: zero count starts nothing
    start(0);
    @(negedge clk);
    chk(!xferStatus[0] && csN == 2'b11, "R1 zero count ignored", xferStatus, 0);

    // R3 R5 R7 R8: byte port on cs 1, single lane timing
    csSel = 1'b1;
    setCfg(1'b1, 1, 1'b0);
    pushByte(8'h96);
    chk(xferStatus[31:16] == 16'd63 && !wrEmpty, "R8 free after byte", 32'(xferStatus[31:16]), 63);
    base = capIdx; r0 = rises; h0 = hiCycles;
    start(1);
    chk(csN == 2'b01, "R3 cs1 selected", 32'(csN), 1);
    waitIdle();
    chk(capBytes[base % 512] == 8'h96, "R7 byte port", 32'(capBytes[base % 512]), 32'h96);
    chk(rises - r0 == 8, "R5 rising edges per byte", rises - r0, 8);
    chk(hiCycles - h0 == 16, "R5 high phase two cycles", hiCycles - h0, 16);
    chk(xferStatus[31:16] == 16'd64 && wrEmpty, "R8 free after drain", 32'(xferStatus[31:16]), 64);
    csSel = 1'b0;

    // R4: hold-select keeps cs low, then released
    setCfg(1'b1, 3, 1'b1);
    base = capIdx;
    pushByte(8'h3C);
    start(1);
    waitIdle();
    repeat (2) @(negedge clk);
    chk(csN == 2'b10, "R4 cs held", 32'(csN), 2);
    setCfg(1'b1, 3, 1'b0);
    pushByte(8'hC3);
    start(1);
    waitIdle();
    chk(csN == 2'b11, "R4 cs released after last", 32'(csN), 3);
    chk({capBytes[base % 512], capBytes[(base + 1) % 512]} == 16'h3CC3, "R4 held bytes",
        {capBytes[base % 512], capBytes[(base + 1) % 512]}, 32'h3CC3);

    // R14: stall on empty write FIFO
    setCfg(1'b1, 2, 1'b0);
    base = capIdx;
    pushByte(8'h81);
    start(2);
    repeat (60) @(negedge clk);
    chk(xferStatus[0] && !sclk && csN == 2'b10, "R14 stalled", {xferStatus[0], sclk, csN}, 32'h2 | 32'h8);
    pushByte(8'h7E);
    waitIdle();
    chk({capBytes[base % 512], capBytes[(base + 1) % 512]} == 16'h817E, "R14 resumed",
        {capBytes[base % 512], capBytes[(base + 1) % 512]}, 32'h817E);

    // R2: setup latched at start, reserved bits drop a write
    setCfg(1'b1, 1, 1'b0);
    base = capIdx;
    pushByte(8'hB4);
    start(1);
    @(negedge clk); cfgData = {1'b0, 4'b0, 3'd3, 1'b1}; cfgWe = 1'b1;
    @(negedge clk); cfgWe = 1'b0;
    waitIdle();
    chk(capBytes[base % 512] == 8'hB4, "R2 setup latched", 32'(capBytes[base % 512]), 32'hB4);
    setCfg(1'b1, 1, 1'b0);
    @(negedge clk); cfgData = {1'b0, 4'b0100, 3'd3, 1'b1}; cfgWe = 1'b1;
    @(negedge clk); cfgWe = 1'b0;
    base = capIdx;
    pushByte(8'h5A);
    start(1);
    waitIdle();
    chk(capBytes[base % 512] == 8'h5A, "R2 reserved write dropped", 32'(capBytes[base % 512]), 32'h5A);

    // R12: hold released, wp kept
    holdEn = 1'b0;
    @(negedge clk);
    chk(ioOe[3:2] == 2'b01 && ioOut[2], "R12 hold released", 32'(ioOe), 32'h4);
    holdEn = 1'b1;

    // R11: overrun then drain, underrun
    for (int i = 0; i < 16; i++) pushWord(32'h01010101 * (i + 1));
    chk(xferStatus[31:16] == 16'd0, "R8 full", 32'(xferStatus[31:16]), 0);
    pushByte(8'hEE);
    chk(errFlags == 2'b01 && xferStatus[31:16] == 16'd0, "R11 overrun", 32'(errFlags), 1);
    @(negedge clk); errClr = 2'b01;
    @(negedge clk); errClr = 2'b00;
    chk(errFlags == 2'b00, "R11 overrun cleared", 32'(errFlags), 0);
    setCfg(1'b1, 3, 1'b0);
    start(64);
    waitIdle();
    chk(xferStatus[31:16] == 16'd64, "R11 drained", 32'(xferStatus[31:16]), 64);
    popRead(d);
    chk(errFlags == 2'b10 && d == 32'd0, "R11 underrun", {d[29:0], errFlags}, 2);
    @(negedge clk); errClr = 2'b10;
    @(negedge clk); errClr = 2'b00;
    chk(errFlags == 2'b00, "R11 underrun cleared", 32'(errFlags), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule